// File: doc/BRIEF.md
# Bridge ADC Serial Responder

This block is the device side of a two-wire weigh-scale converter link. A local sample source hands it 24-bit conversion words. A host reads each word by sending pulses on a serial clock line. The block shows that a word is waiting by pulling its data line low. It shifts the word out most significant bit first, one bit for each host rising edge. It then counts the extra pulses to choose the channel and gain for the next conversion.

The host clock is asynchronous to the system clock. The block brings it in through a two-flop synchronizer and finds its edges in the system clock domain. A read cycle ends when the host clock has stayed low for a configurable number of system cycles. At that point the pulse count is decoded, or a sticky error is raised if the count is not allowed. If the host holds the clock high for long enough, the block enters power-down. When the clock falls again, the block restarts from its reset state.

Top module: `bridge_adc_responder`

## Requirements
- R1: After reset the data line is high, sel_code is 0 (channel A, gain 128), err is 0 and pwr_down is 0.
- R2: A sample accepted while no read cycle is in progress drives the data line low on the following cycle. With no unread word, the data line stays high.
- R3: Each synchronized rising edge of the host clock presents the next bit of the word, bit 23 first. The new bit appears on the data line three system clock cycles after the host clock pin rises.
- R4: Once 24 bits have been shifted, every further pulse in the same cycle presents a 1.
- R5: A cycle ends after the synchronized host clock has been low for IDLE_CYCLES consecutive system cycles. A count of 25 pulses sets sel_code 0 (channel A, gain 128), 26 sets 1 (channel B, gain 32), and 27 sets 2 (channel A, gain 64). The value 3 never appears.
- R6: A cycle that ends with fewer than 25 or more than 27 pulses sets err and leaves sel_code unchanged. err then stays set, even across later legal cycles, until a power-down restart or rst_n clears it.
- R7: A sample that arrives while a read cycle is in progress is held. When that cycle ends, the data line goes low and the next read returns the held word.
- R8: If the synchronized host clock stays high for PD_CYCLES system cycles, pwr_down goes to 1. It stays 1 for as long as the clock stays high, and the data line is high throughout.
- R9: A falling host clock during power-down clears pwr_down and err, sets sel_code to 0, drives the data line high, and drops any unread word.
- R10: Samples offered during power-down are ignored. After the restart the data line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| sdata_out | output | 1 | Serial data to host; low means a word is ready |
| smp_data | input | 24 | Conversion word from the sample source |
| smp_valid | input | 1 | One-cycle strobe that accepts smp_data |
| sel_code | output | 2 | Channel/gain for the next conversion: 0 A/128, 1 B/32, 2 A/64 |
| pwr_down | output | 1 | Power-down state |
| err | output | 1 | Sticky pulse-count error |

## Verification
The hardest situation to reach is a sample arriving in the middle of a read. The held word must then be presented only after the idle timeout ends the cycle, and not mixed into the bits being shifted. The bench reaches it by pushing a new word from the host read task between two pulses, while the clock is still high. It then reads the next word in full. Power-down with a pending error and a non-default selection is also reached on purpose. An illegal-count cycle and a 27-pulse cycle come first, then the clock is held high past the threshold while a sample is offered. Every cycle the bench compares the outputs with a behavioural model.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

    localparam int WORD_W = 24;
    localparam int CNT_W  = 5;

    typedef enum logic [1:0] {
        SEL_A128 = 2'd0,
        SEL_B32  = 2'd1,
        SEL_A64  = 2'd2
    } sel_e;

    function automatic logic pulses_legal(input logic [CNT_W-1:0] n);
        return (n >= CNT_W'(WORD_W + 1)) && (n <= CNT_W'(WORD_W + 3));
    endfunction

    function automatic sel_e pulses_to_sel(input logic [CNT_W-1:0] n);
        sel_e s;
        case (n)
            CNT_W'(WORD_W + 2): s = SEL_B32;
            CNT_W'(WORD_W + 3): s = SEL_A64;
            default:            s = SEL_A128;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adc_resp_sync.sv
module adc_resp_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1   = async_in;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl  = q.s2;
    assign rise = q.s2 & ~q.prev;
    assign fall = ~q.s2 & q.prev;
endmodule

// File: rtl/adc_resp_hitimer.sv
module adc_resp_hitimer #(
    parameter int LIMIT = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic expired
);
    localparam int HI_W = $clog2(LIMIT + 1);
    localparam logic [HI_W-1:0] TOP = HI_W'(LIMIT - 1);

    logic [HI_W-1:0] hi_q, hi_d;

    always_comb begin
        if (!lvl)             hi_d = '0;
        else if (hi_q == TOP) hi_d = hi_q;
        else                  hi_d = hi_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
    end

    assign expired = lvl && (hi_q == TOP);
endmodule

// File: rtl/bridge_adc_responder.sv
module bridge_adc_responder
    import adc_resp_pkg::*;
#(
    parameter int PD_CYCLES   = 15000,
    parameter int IDLE_CYCLES = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    output logic              sdata_out,
    input  logic [WORD_W-1:0] smp_data,
    input  logic              smp_valid,
    output logic [1:0]        sel_code,
    output logic              pwr_down,
    output logic              err
);
    localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [IDLE_W-1:0] IDLE_TOP = IDLE_W'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] hold_w;
        logic              hold_v;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [IDLE_W-1:0] idle;
        logic              sdo;
        sel_e              sel;
        logic              err;
        logic              pd;
    } core_t;

    function automatic core_t core_init();
        core_t c;
        c.word   = '1;
        c.hold_w = '0;
        c.hold_v = 1'b0;
        c.busy   = 1'b0;
        c.cnt    = '0;
        c.idle   = '0;
        c.sdo    = 1'b1;
        c.sel    = SEL_A128;
        c.err    = 1'b0;
        c.pd     = 1'b0;
        return c;
    endfunction

    logic sclk_lvl, sclk_rise, sclk_fall, pd_hit;
    core_t q, d;

    adc_resp_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .lvl      (sclk_lvl),
        .rise     (sclk_rise),
        .fall     (sclk_fall)
    );

    adc_resp_hitimer #(.LIMIT(PD_CYCLES)) u_hitimer (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (sclk_lvl),
        .expired (pd_hit)
    );

    always_comb begin
        d      = q;
        d.idle = '0;
        if (q.pd) begin
            if (sclk_fall) d = core_init();
        end else if (pd_hit) begin
            d.pd   = 1'b1;
            d.busy = 1'b0;
            d.cnt  = '0;
            d.sdo  = 1'b1;
        end else begin
            if (q.busy && !sclk_lvl) begin
                if (q.idle == IDLE_TOP) begin
                    if (pulses_legal(q.cnt)) d.sel = pulses_to_sel(q.cnt);
                    else                     d.err = 1'b1;
                    d.busy = 1'b0;
                    d.cnt  = '0;
                    if (q.hold_v) begin
                        d.word   = q.hold_w;
                        d.sdo    = 1'b0;
                        d.hold_v = 1'b0;
                    end else begin
                        d.word = '1;
                        d.sdo  = 1'b1;
                    end
                end else begin
                    d.idle = q.idle + 1'b1;
                end
            end
            if (sclk_rise) begin
                d.busy = 1'b1;
                if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
                d.sdo  = q.word[WORD_W-1];
                d.word = {q.word[WORD_W-2:0], 1'b1};
            end
            if (smp_valid) begin
                if (d.busy) begin
                    d.hold_w = smp_data;
                    d.hold_v = 1'b1;
                end else begin
                    d.word = smp_data;
                    d.sdo  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= core_init();
        else        q <= d;
    end

    logic busy_w;
    assign busy_w    = q.busy;
    assign sdata_out = q.sdo;
    assign sel_code  = q.sel;
    assign pwr_down  = q.pd;
    assign err       = q.err;
endmodule

// File: rtl/adc_resp_chk.sv
module adc_resp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lvl,
    input logic       fall,
    input logic       busy,
    input logic       smp_valid,
    input logic       sdo,
    input logic [1:0] sel,
    input logic       pd,
    input logic       err
);
    a_r2_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !busy && !lvl && !pd) |=> !sdo);

    a_r5_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'd3);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(pd && fall)) |=> err);

    a_r8_pd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && lvl) |=> pd);

    a_r8_pd_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> sdo);

    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && fall) |=> (!pd && !err && sel == 2'd0 && sdo));
endmodule

bind bridge_adc_responder adc_resp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (sclk_lvl),
    .fall      (sclk_fall),
    .busy      (busy_w),
    .smp_valid (smp_valid),
    .sdo       (sdata_out),
    .sel       (sel_code),
    .pd        (pwr_down),
    .err       (err)
);

// File: tb/test_bridge_adc_responder.sv
module test_bridge_adc_responder;
    localparam int PD   = 40;
    localparam int IDLE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0;
    logic [23:0] smp_data = '0;
    logic smp_valid = 1'b0;
    logic sdata_out, pwr_down, err;
    logic [1:0] sel_code;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    bridge_adc_responder #(.PD_CYCLES(PD), .IDLE_CYCLES(IDLE)) i_bridge_adc_responder (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_out(sdata_out),
        .smp_data(smp_data), .smp_valid(smp_valid), .sel_code(sel_code),
        .pwr_down(pwr_down), .err(err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: integers and a delay queue for the synchronizer
    bit sq[$] = '{0, 0};
    bit m_last = 0;
    int m_hi = 0, m_idle = 0, m_cnt = 0, m_sel = 0;
    bit m_busy = 0, m_sdo = 1, m_err = 0, m_pd = 0, m_hv = 0;
    logic [23:0] m_word = '1, m_hw = '0;

    always @(posedge clk) begin
        bit lv, rs, fl, hit;
        lv  = sq[1];
        rs  = lv && !m_last;
        fl  = !lv && m_last;
        hit = lv && (m_hi == PD - 1);
        if (!rst_n) begin
            sq = '{0, 0}; m_last = 0; m_hi = 0; m_idle = 0; m_cnt = 0; m_sel = 0;
            m_busy = 0; m_sdo = 1; m_err = 0; m_pd = 0; m_hv = 0; m_word = '1;
        end else begin
            if (m_pd) begin
                m_idle = 0;
                if (fl) begin
                    m_word = '1; m_hv = 0; m_busy = 0; m_cnt = 0;
                    m_sdo = 1; m_sel = 0; m_err = 0; m_pd = 0;
                end
            end else if (hit) begin
                m_idle = 0; m_pd = 1; m_busy = 0; m_cnt = 0; m_sdo = 1;
            end else begin
                if (m_busy && !lv) begin
                    if (m_idle == IDLE - 1) begin
                        m_idle = 0;
                        if (m_cnt == 25) m_sel = 0;
                        else if (m_cnt == 26) m_sel = 1;
                        else if (m_cnt == 27) m_sel = 2;
                        else m_err = 1;
                        m_busy = 0; m_cnt = 0;
                        if (m_hv) begin m_word = m_hw; m_sdo = 0; m_hv = 0; end
                        else begin m_word = '1; m_sdo = 1; end
                    end else m_idle++;
                end else m_idle = 0;
                if (rs) begin
                    m_busy = 1;
                    if (m_cnt < 31) m_cnt++;
                    m_sdo = m_word[23];
                    m_word = {m_word[22:0], 1'b1};
                end
                if (smp_valid) begin
                    if (m_busy) begin m_hw = smp_data; m_hv = 1; end
                    else begin m_word = smp_data; m_sdo = 0; end
                end
            end
            m_hi = lv ? ((m_hi == PD - 1) ? m_hi : m_hi + 1) : 0;
            m_last = lv;
            sq.push_front(sclk_in);
            void'(sq.pop_back());
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(sdata_out == m_sdo, "R3 model data line", sdata_out, m_sdo);
            check(sel_code == 2'(m_sel), "R5 model sel_code", sel_code, m_sel);
            check(err == m_err, "R6 model err", err, m_err);
            check(pwr_down == m_pd, "R8 model pwr_down", pwr_down, m_pd);
        end
    end

    task automatic push(input logic [23:0] v);
        @(negedge clk); smp_data = v; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic host_read(input int n, input int pk, input logic [23:0] pv, output logic [23:0] got);
        got = '0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk); sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            if (k <= 24) got = {got[22:0], sdata_out};
            else check(sdata_out == 1'b1, "R4 extra pulse reads 1", sdata_out, 1);
            if (k == pk) begin
                smp_data = pv; smp_valid = 1'b1;
                @(negedge clk); smp_valid = 1'b0;
            end
            sclk_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (14) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1;
        // R1 reset state
        check(sdata_out == 1'b1, "R1 line high", sdata_out, 1);
        check(sel_code == 2'd0, "R1 sel A128", sel_code, 0);
        check(err == 1'b0, "R1 no err", err, 0);
        check(pwr_down == 1'b0, "R1 not powered down", pwr_down, 0);
        repeat (5) @(negedge clk);
        check(sdata_out == 1'b1, "R2 no word keeps line high", sdata_out, 1);

        push(24'hA5C396);
        check(sdata_out == 1'b0, "R2 ready pulls low", sdata_out, 0);
        host_read(25, 0, '0, got);
        check(got == 24'hA5C396, "R3 word MSB first", got, 24'hA5C396);
        check(sel_code == 2'd0 && !err, "R5 25 pulses A128", sel_code, 0);
        check(sdata_out == 1'b1, "R2 line high after read", sdata_out, 1);

        push(24'h13579B);
        host_read(26, 0, '0, got);
        check(got == 24'h13579B, "R3 second word", got, 24'h13579B);
        check(sel_code == 2'd1, "R5 26 pulses B32", sel_code, 1);

        push(24'h800001);
        host_read(27, 0, '0, got);
        check(got == 24'h800001, "R3 edge bits", got, 24'h800001);
        check(sel_code == 2'd2, "R5 27 pulses A64", sel_code, 2);

        // R7 sample during read is held
        push(24'h0F0F0F);
        host_read(25, 10, 24'hC0FFEE, got);
        check(got == 24'h0F0F0F, "R7 current word intact", got, 24'h0F0F0F);
        check(sdata_out == 1'b0, "R7 held word ready", sdata_out, 0);
        host_read(25, 0, '0, got);
        check(got == 24'hC0FFEE, "R7 held word read", got, 24'hC0FFEE);

        // R6 short cycle error, sticky across a legal cycle
        push(24'h123456);
        host_read(20, 0, '0, got);
        check(err == 1'b1, "R6 short count err", err, 1);
        check(sel_code == 2'd0, "R6 sel unchanged", sel_code, 0);
        push(24'h654321);
        host_read(27, 0, '0, got);
        check(err == 1'b1, "R6 err sticky", err, 1);
        check(sel_code == 2'd2, "R5 legal cycle after err", sel_code, 2);

        // R8 power-down, R10 sample ignored
        @(negedge clk); sclk_in = 1'b1;
        repeat (50) @(negedge clk);
        check(pwr_down == 1'b1, "R8 enter power-down", pwr_down, 1);
        push(24'h000000);
        repeat (20) @(negedge clk);
        check(pwr_down == 1'b1, "R8 stays powered down", pwr_down, 1);
        check(sdata_out == 1'b1, "R10 sample ignored in power-down", sdata_out, 1);
        sclk_in = 1'b0;
        repeat (6) @(negedge clk);
        check(pwr_down == 1'b0, "R9 restart leaves power-down", pwr_down, 0);
        check(err == 1'b0, "R9 err cleared", err, 0);
        check(sel_code == 2'd0, "R9 sel back to A128", sel_code, 0);
        check(sdata_out == 1'b1, "R10 no word after restart", sdata_out, 1);

        // R6 long cycle
        push(24'hFEDCBA);
        host_read(28, 0, '0, got);
        check(got == 24'hFEDCBA, "R3 word before long cycle", got, 24'hFEDCBA);
        check(err == 1'b1, "R6 long count err", err, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule